// File: doc/BRIEF.md
# Elastic Merge-Tree Output Port

This block is one output port of a wormhole switch for a two-dimensional mesh. There is no input buffer and no central crossbar. The N input links of the port feed a tree of small merge stages. Each stage chooses one of its RADIX inputs in round-robin order, steers that flit through a multiplexer and holds it in a two-slot elastic register. The outputs of the leaf stages feed the next level, and the root stage drives the outgoing link. Every link uses a req/ready handshake, and a flit moves on a clock edge at which both req and ready are high.

Each stage locks onto the input whose head flit it accepted and keeps that lock until the tail flit passes. Packets from different inputs therefore leave the port whole. When N is not a power of RADIX, the tree is padded with inputs that never request.

The root stage rewrites every head flit with lookahead dimension-ordered routing. It takes the coordinates of the next switch, which are the switch's own coordinates moved one hop in the port's direction. It then compares them with the flit's destination and writes into the head flit the output that flit will need at that next switch.

Top module: `otree_port`

## Requirements
- R1: A flit moves on a link at a clock edge where req and ready are both high. While out_req is high and out_ready is low, out_req stays high and out_flit does not change.
- R2: The tree has LV levels, where LV is the smallest L ≥ 1 with RADIX^L ≥ N_IN. A flit accepted into an empty tree is on out_flit exactly LV cycles after its input edge (3 for 5 inputs, radix 2).
- R3: Every tree stage holds at most two flits. If out_ready is held low and all inputs keep requesting, the port accepts flits until every stage reachable from a live input is full. That is 12 flits for 5 inputs at radix 2. After that, every in_ready is low.
- R4: No flit is lost or duplicated, and the flits of each input leave in the order they entered, under any pattern of output stalls and input gaps.
- R5: Packets never interleave at the output. After a head flit that is not also a tail leaves, only flits of the same packet leave until its tail. Flit kind is in bits [1:0]: 01 head, 00 body, 10 tail, 11 single-flit packet.
- R6: Padding inputs (tree positions N_IN and above) are never granted. All N_IN real inputs are served, including one whose leaf stage shares only padding.
- R7: On a head flit (bit 0 set), the port overwrites bits [4:2] with the next switch's output code: 0 local, 1 east (+x), 2 west (−x), 3 north (+y), 4 south (−y). X is corrected first, then Y. Destination X is in bits [4+C:5] and destination Y in bits [4+2C:5+C], where C is COORD_W. The next switch is (HERE_X, HERE_Y) moved one hop in direction LINK_DIR, which uses the same codes.
- R8: Body and tail flits leave bit for bit unchanged, including bits [4:2].
- R9: During and right after reset, out_req and every in_ready are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | N_IN | Flit valid, one bit per input link |
| in_ready | output | N_IN | Flit taken this edge, one bit per input link |
| in_flit | input | N_IN×FLIT_W | Flit per input link |
| out_req | output | 1 | Outgoing flit valid |
| out_ready | input | 1 | Downstream can take a flit |
| out_flit | output | FLIT_W | Outgoing flit, head flits carry the rewritten next-hop field |

## Verification
The bench uses 5 inputs at radix 2, which adds three padding leaves. Each input sends 64 packets of one to four flits, and together the head destinations cover every one of the 64 (x, y) pairs. This separates all five next-hop codes, including the X-before-Y order. The test runs in five phases:
- A lone flit into an empty tree measures the level latency.
- A full output stall starting from empty counts the total buffer capacity, which shows whether any stage holds more or fewer than two flits.
- Free-flowing traffic runs with the output always ready.
- Traffic with irregular output stalls and input gaps exposes lost, reordered or interleaved flits.
- A final drain shows whether the input that shares its leaf stage with padding is fully served.

// File: rtl/otree_pkg.sv
package otree_pkg;

  // flit field positions
  localparam int KIND_LSB  = 0;
  localparam int PORT_LSB  = 2;
  localparam int PORT_W    = 3;
  localparam int COORD_LSB = 5;

  // next-hop direction codes
  localparam logic [2:0] DIR_LOCAL = 3'd0;
  localparam logic [2:0] DIR_EAST  = 3'd1;
  localparam logic [2:0] DIR_WEST  = 3'd2;
  localparam logic [2:0] DIR_NORTH = 3'd3;
  localparam logic [2:0] DIR_SOUTH = 3'd4;

  function automatic int ipow(int b, int e);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = r * b;
    return r;
  endfunction

  // smallest level count (at least one) whose fan-in covers n
  function automatic int tree_levels(int n, int m);
    int lv;
    int span;
    lv = 1;
    span = m;
    for (int i = 0; i < 30; i++) begin
      if (span < n) begin
        span = span * m;
        lv = lv + 1;
      end
    end
    return lv;
  endfunction

  // first wire index of level l in the flattened wire array
  function automatic int level_base(int l, int lv, int m);
    int acc;
    acc = 0;
    for (int k = 0; k < l; k++) acc = acc + ipow(m, lv - k);
    return acc;
  endfunction

  function automatic int dir_dx(int d);
    return (d == 1) ? 1 : (d == 2) ? -1 : 0;
  endfunction

  function automatic int dir_dy(int d);
    return (d == 3) ? 1 : (d == 4) ? -1 : 0;
  endfunction

  // X-first dimension-ordered decision taken at switch (nx, ny)
  function automatic logic [2:0] dor_port(int nx, int ny, int tx, int ty);
    if (tx > nx) return DIR_EAST;
    if (tx < nx) return DIR_WEST;
    if (ty > ny) return DIR_NORTH;
    if (ty < ny) return DIR_SOUTH;
    return DIR_LOCAL;
  endfunction

  function automatic logic kind_is_head(logic [1:0] k);
    return k[0];
  endfunction

  function automatic logic kind_is_tail(logic [1:0] k);
    return k[1];
  endfunction

endpackage

// File: rtl/otree_rr.sv
module otree_rr #(
  parameter int WAYS = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [WAYS-1:0]                       req,
  input  logic                                  en,
  input  logic                                  hold,
  input  logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] hold_idx,
  output logic [WAYS-1:0]                       gnt,
  output logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] gnt_idx
);
  localparam int IW = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [IW-1:0] last_q;
  logic          found;
  int            cand;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    cand    = 0;
    if (en) begin
      if (hold) begin
        if (req[hold_idx]) begin
          gnt[hold_idx] = 1'b1;
          gnt_idx       = hold_idx;
        end
      end else begin
        for (int k = 1; k <= WAYS; k++) begin
          cand = (int'(last_q) + k) % WAYS;
          if (!found && req[cand]) begin
            found     = 1'b1;
            gnt[cand] = 1'b1;
            gnt_idx   = IW'(cand);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IW'(WAYS - 1);
    else if (|gnt) last_q <= gnt_idx;
  end

endmodule

// File: rtl/otree_route.sv
module otree_route
  import otree_pkg::*;
#(
  parameter int FLIT_W   = 24,
  parameter int COORD_W  = 3,
  parameter int HERE_X   = 2,
  parameter int HERE_Y   = 2,
  parameter int LINK_DIR = 1
) (
  input  logic [FLIT_W-1:0] flit_in,
  output logic [FLIT_W-1:0] flit_out
);
  localparam int NEXT_X = HERE_X + dir_dx(LINK_DIR);
  localparam int NEXT_Y = HERE_Y + dir_dy(LINK_DIR);

  logic [COORD_W-1:0] dest_x, dest_y;
  logic [2:0]         hop;

  assign dest_x = flit_in[COORD_LSB +: COORD_W];
  assign dest_y = flit_in[COORD_LSB + COORD_W +: COORD_W];
  assign hop    = dor_port(NEXT_X, NEXT_Y, int'(dest_x), int'(dest_y));

  always_comb begin
    flit_out = flit_in;
    if (kind_is_head(flit_in[KIND_LSB +: 2])) flit_out[PORT_LSB +: PORT_W] = hop;
  end

endmodule

// File: rtl/otree_merge.sv
module otree_merge
  import otree_pkg::*;
#(
  parameter int RADIX    = 2,
  parameter int FLIT_W   = 24,
  parameter bit DO_ROUTE = 0,
  parameter int COORD_W  = 3,
  parameter int HERE_X   = 2,
  parameter int HERE_Y   = 2,
  parameter int LINK_DIR = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [RADIX-1:0]             up_req,
  output logic [RADIX-1:0]             up_ready,
  input  logic [RADIX-1:0][FLIT_W-1:0] up_flit,
  output logic                         dn_req,
  input  logic                         dn_ready,
  output logic [FLIT_W-1:0]            dn_flit
);
  localparam int IW = (RADIX > 1) ? $clog2(RADIX) : 1;

  logic [1:0]        fill_q;
  logic [FLIT_W-1:0] slot0_q, slot1_q;
  logic              locked_q;
  logic [IW-1:0]     lock_idx_q;

  // named internal events
  logic              has_space;
  logic [RADIX-1:0]  gnt;
  logic [IW-1:0]     gnt_idx;
  logic              push, pop;
  logic [FLIT_W-1:0] picked, stored;

  assign has_space = (fill_q != 2'd2);

  otree_rr #(.WAYS(RADIX)) i_rr (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (up_req),
    .en       (has_space),
    .hold     (locked_q),
    .hold_idx (lock_idx_q),
    .gnt      (gnt),
    .gnt_idx  (gnt_idx)
  );

  assign up_ready = gnt;
  assign push     = |gnt;
  assign picked   = up_flit[gnt_idx];
  assign dn_req   = (fill_q != 2'd0);
  assign dn_flit  = slot0_q;
  assign pop      = dn_req && dn_ready;

  generate
    if (DO_ROUTE) begin : g_route
      otree_route #(
        .FLIT_W(FLIT_W), .COORD_W(COORD_W),
        .HERE_X(HERE_X), .HERE_Y(HERE_Y), .LINK_DIR(LINK_DIR)
      ) i_route (
        .flit_in  (picked),
        .flit_out (stored)
      );
    end else begin : g_pass
      assign stored = picked;
    end
  endgenerate

  // packet lock: keep the granted input until its tail passes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q   <= 1'b0;
      lock_idx_q <= '0;
    end else if (push) begin
      locked_q   <= !kind_is_tail(picked[KIND_LSB +: 2]);
      lock_idx_q <= gnt_idx;
    end
  end

  // two-slot elastic register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q  <= 2'd0;
      slot0_q <= '0;
      slot1_q <= '0;
    end else begin
      case ({push, pop})
        2'b10: begin
          if (fill_q == 2'd0) slot0_q <= stored;
          else                slot1_q <= stored;
          fill_q <= fill_q + 2'd1;
        end
        2'b01: begin
          slot0_q <= slot1_q;
          fill_q  <= fill_q - 2'd1;
        end
        2'b11: begin
          if (fill_q == 2'd1) slot0_q <= stored;
          else begin
            slot0_q <= slot1_q;
            slot1_q <= stored;
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ready |=> dn_req && $stable(dn_flit));

  // R5
  stage_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && !kind_is_tail(picked[KIND_LSB +: 2]) |=> !push || (gnt_idx == $past(gnt_idx)));

endmodule

// File: rtl/otree_port.sv
module otree_port
  import otree_pkg::*;
#(
  parameter int N_IN     = 5,
  parameter int RADIX    = 2,
  parameter int FLIT_W   = 24,
  parameter int COORD_W  = 3,
  parameter int HERE_X   = 2,
  parameter int HERE_Y   = 2,
  parameter int LINK_DIR = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_IN-1:0]             in_req,
  output logic [N_IN-1:0]             in_ready,
  input  logic [N_IN-1:0][FLIT_W-1:0] in_flit,
  output logic                        out_req,
  input  logic                        out_ready,
  output logic [FLIT_W-1:0]           out_flit
);
  localparam int LV    = tree_levels(N_IN, RADIX);
  localparam int PAD   = ipow(RADIX, LV);
  localparam int TOTAL = level_base(LV + 1, LV, RADIX);
  localparam int ROOT  = TOTAL - 1;

  logic              w_req   [TOTAL];
  logic              w_ready [TOTAL];
  logic [FLIT_W-1:0] w_flit  [TOTAL];

  genvar gi, gl, gs, gj;

  // leaves: real inputs, then padding that never requests
  generate
    for (gi = 0; gi < PAD; gi++) begin : g_leaf
      if (gi < N_IN) begin : g_real
        assign w_req[gi]    = in_req[gi];
        assign w_flit[gi]   = in_flit[gi];
        assign in_ready[gi] = w_ready[gi];
      end else begin : g_spare
        assign w_req[gi]  = 1'b0;
        assign w_flit[gi] = '0;
        // R6
        spare_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
          !w_ready[gi]);
      end
    end
  endgenerate

  // merge tree, level 0 at the leaves; the root stage routes
  generate
    for (gl = 0; gl < LV; gl++) begin : g_lvl
      for (gs = 0; gs < ipow(RADIX, LV - 1 - gl); gs++) begin : g_stage
        localparam int SRC = level_base(gl, LV, RADIX) + gs * RADIX;
        localparam int DST = level_base(gl + 1, LV, RADIX) + gs;
        logic [RADIX-1:0]             s_req, s_ready;
        logic [RADIX-1:0][FLIT_W-1:0] s_flit;
        for (gj = 0; gj < RADIX; gj++) begin : g_in
          assign s_req[gj]         = w_req[SRC + gj];
          assign s_flit[gj]        = w_flit[SRC + gj];
          assign w_ready[SRC + gj] = s_ready[gj];
        end
        otree_merge #(
          .RADIX(RADIX), .FLIT_W(FLIT_W), .DO_ROUTE(gl == LV - 1),
          .COORD_W(COORD_W), .HERE_X(HERE_X), .HERE_Y(HERE_Y), .LINK_DIR(LINK_DIR)
        ) i_stage (
          .clk      (clk),
          .rst_n    (rst_n),
          .up_req   (s_req),
          .up_ready (s_ready),
          .up_flit  (s_flit),
          .dn_req   (w_req[DST]),
          .dn_ready (w_ready[DST]),
          .dn_flit  (w_flit[DST])
        );
      end
    end
  endgenerate

  assign out_req       = w_req[ROOT];
  assign out_flit      = w_flit[ROOT];
  assign w_ready[ROOT] = out_ready;

  // checker state: a packet is open at the output link
  logic out_fire, pkt_open_q;
  assign out_fire = out_req && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) pkt_open_q <= 1'b0;
    else if (out_fire) pkt_open_q <= !kind_is_tail(out_flit[KIND_LSB +: 2]);
  end

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_req && (in_ready == '0));

  // R1
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && !out_ready |=> out_req && $stable(out_flit));

  // R5
  no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && pkt_open_q |-> !kind_is_head(out_flit[KIND_LSB +: 2]));

  // R5
  head_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && !pkt_open_q |-> kind_is_head(out_flit[KIND_LSB +: 2]));

  // R7
  hop_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && kind_is_head(out_flit[KIND_LSB +: 2]) |-> out_flit[PORT_LSB +: PORT_W] <= 3'd4);

endmodule

// File: tb/test_otree_port.sv
`timescale 1ns/1ps
module test_otree_port;
  localparam int N = 5;
  localparam int FW = 24;
  localparam int NPKT = 64;
  localparam int SLEN = 160;   // flits per input: 64 + 16*(0+1+2+3)
  localparam int NX = 3;       // next switch: (2,2) one hop east
  localparam int NY = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] in_req = '0;
  logic [N-1:0] in_ready;
  logic [N-1:0][FW-1:0] in_flit = '0;
  logic out_req;
  logic out_ready = 1'b0;
  logic [FW-1:0] out_flit;

  always #2 clk = ~clk;

  otree_port #(.N_IN(N), .RADIX(2), .FLIT_W(FW), .COORD_W(3),
               .HERE_X(2), .HERE_Y(2), .LINK_DIR(1)) i_otree_port (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ready(in_ready),
    .in_flit(in_flit), .out_req(out_req), .out_ready(out_ready), .out_flit(out_flit));

  int tests = 0, fails = 0;
  logic [FW-1:0] stream [N][SLEN];
  int ptr [N], lim [N], nxt [N];
  bit en [N];
  bit took [N];
  int cyc = 0, accepted = 0, first_in = -1, first_out = -1, open_src = -1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] hop_of(int tx, int ty);
    if (tx != NX) return (tx > NX) ? 3'd1 : 3'd2;
    if (ty != NY) return (ty > NY) ? 3'd3 : 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [FW-1:0] expect_flit(int s, int k);
    logic [FW-1:0] f;
    f = stream[s][k];
    if (f[0]) f[4:2] = hop_of(int'(f[7:5]), int'(f[10:8]));
    return f;
  endfunction

  task automatic check_out(input logic [FW-1:0] f);
    int s, k;
    s = int'(f[13:11]);
    k = int'(f[23:14]);
    chk(s < N, "R4 source field", 32'(s), 32'(N - 1));
    if (s < N) begin
      chk(k == nxt[s], "R4 order per input", 32'(k), 32'(nxt[s]));
      if (k < SLEN) chk(f == expect_flit(s, k), f[0] ? "R7 head rewrite" : "R8 body unchanged",
                        32'(f), 32'(expect_flit(s, k)));
      if (open_src >= 0) chk(s == open_src, "R5 no interleave", 32'(s), 32'(open_src));
      open_src = f[1] ? -1 : s;
      nxt[s] = k + 1;
    end
  endtask

  task automatic step(input bit ordy, input bit gaps);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      in_req[i]  = en[i] && (ptr[i] < lim[i]) && !(gaps && ((cyc + i) % 3 == 0));
      in_flit[i] = (ptr[i] < SLEN) ? stream[i][ptr[i]] : '0;
    end
    out_ready = ordy;
    #1;
    for (int i = 0; i < N; i++) took[i] = in_req[i] && in_ready[i];
    if (out_req && first_out < 0) first_out = cyc;
    if (out_req && out_ready) check_out(out_flit);
    @(posedge clk);
    for (int i = 0; i < N; i++) if (took[i]) begin
      ptr[i]++;
      accepted++;
      if (first_in < 0) first_in = cyc;
    end
    cyc++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // build streams: input i, packet p, length 1..4, destinations cover all 64 pairs
    for (int i = 0; i < N; i++) begin
      int k;
      k = 0;
      for (int p = 0; p < NPKT; p++) begin
        int len;
        len = 1 + ((i + p) % 4);
        for (int f = 0; f < len; f++) begin
          logic [1:0] kind;
          logic [8:0] mid;
          kind = (len == 1) ? 2'b11 : (f == 0) ? 2'b01 : (f == len - 1) ? 2'b10 : 2'b00;
          if (kind[0]) mid = {3'((p / 8 + i) % 8), 3'(p % 8), 3'd7};
          else         mid = 9'((k * 5) % 512);
          stream[i][k] = {10'(k), 3'(i), mid, kind};
          k++;
        end
      end
      ptr[i] = 0; lim[i] = 0; nxt[i] = 0; en[i] = 1'b0;
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_req == 1'b0, "R9 out_req in reset", 32'(out_req), 0);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    #1;
    chk(out_req == 1'b0, "R9 out_req after reset", 32'(out_req), 0);
    chk(in_ready == '0, "R9 in_ready after reset", 32'(in_ready), 0);

    // lone flit through an empty tree
    en[0] = 1'b1; lim[0] = 1;
    repeat (8) step(1'b1, 1'b0);
    chk(first_out - first_in == 3, "R2 level latency", 32'(first_out - first_in), 3);

    // full stall from empty: capacity count
    for (int i = 0; i < N; i++) begin en[i] = 1'b1; lim[i] = SLEN; end
    accepted = 0;
    repeat (30) step(1'b0, 1'b0);
    chk(accepted == 12, "R3 stall capacity", 32'(accepted), 12);
    @(negedge clk); #1;
    chk(in_ready == '0, "R3 backpressure at inputs", 32'(in_ready), 0);

    // free flow, then irregular stalls with input gaps
    repeat (120) step(1'b1, 1'b0);
    repeat (400) step(((cyc * 7) % 5) < 3, 1'b1);

    // drain
    for (int n = 0; n < 4000; n++) begin
      bit done;
      done = 1'b1;
      for (int s = 0; s < N; s++) if (nxt[s] != SLEN) done = 1'b0;
      if (!done) step(1'b1, 1'b0);
    end
    for (int s = 0; s < N; s++) begin
      chk(ptr[s] == SLEN, (s == 4) ? "R6 input accepted all" : "R4 input accepted all", 32'(ptr[s]), SLEN);
      chk(nxt[s] == SLEN, (s == 4) ? "R6 input delivered all" : "R4 input delivered all", 32'(nxt[s]), SLEN);
    end
    chk(open_src == -1, "R5 no packet left open", 32'(open_src), 32'hffffffff);
    @(negedge clk); #1;
    chk(out_req == 1'b0, "R4 no extra flit", 32'(out_req), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule